// File: doc/BRIEF.md
# AFSK Bit Recovery Front End

This block turns a stream of signed 8-bit audio samples, taken at 9600 Hz, into decoded data bits for a 1200 bit/s audio frequency-shift-keyed link. Eight samples make one bit period. Each accepted sample goes through three steps. First, a delay-and-multiply frequency discriminator multiplies it by the sample accepted four samples earlier. Second, a first-order recursive low-pass filter built only from shifts and adds smooths the product. Third, a sign slicer passes the result to a digital bit-timing loop.

The bit-timing loop advances a phase counter on every sample. Whenever the slicer output toggles, the loop pulls the counter toward mid-bit. Each time the counter wraps, the loop decides a raw bit by majority vote over the three newest slicer values. It then emits one NRZI-decoded bit with a one-cycle strobe.

The upstream converter drives `smp_valid` for each new sample. A downstream frame parser consumes `bit_data` whenever `bit_valid` is high. `lpf_sel` chooses between two filter pole positions.

Top module: `afsk_bit_recover`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `bit_valid` and `bit_data` are 0. Reset clears the four-entry delay line to zero, clears the filter input and output history, and clears the slicer history, the phase counter and the previous raw bit to 0.
- R2: For each accepted sample s, the filter input is floor((d × s) / 4), computed with an arithmetic right shift by 2. Here d is the sample accepted exactly four samples earlier, or 0 if fewer than four samples have been accepted since reset.
- R3: With `lpf_sel` = 0, the filter output becomes y' = x_prev + x + (y>>>1) + (y>>>3) + (y>>>5). Here x is the new filter input, x_prev is the previous filter input, and the shifts are arithmetic.
- R4: With `lpf_sel` = 1, the filter output becomes y' = x_prev + x + (y>>>1).
- R5: The slicer appends 1 to its history when y' > 0 and appends 0 otherwise, including when y' is 0. An edge is present when the two newest history entries differ.
- R6: The phase counter runs from 0 to 63. On an edge it first moves up by 1 if it is below 32, and down by 1 otherwise. It then always gains 8. A bit is decided exactly when the result reaches 64 or more, and the counter then drops by 64. So silence from reset gives one bit for every 8 samples, the first one on the 8th sample.
- R7: The raw bit is 1 when at least two of the three newest slicer entries are 1.
- R8: `bit_data` is 1 when the new raw bit equals the previous raw bit, and 0 otherwise.
- R9: `bit_valid` is high for exactly one cycle. It rises after the third rising clock edge, counting the edge that accepted the deciding sample as the first. `bit_data` changes only together with a strobe or a reset.
- R10: Cycles with `smp_valid` low change no state, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; the sample is accepted on this clock edge |
| smp_data | input | 8 | Signed two's-complement audio sample |
| lpf_sel | input | 1 | Filter pole: 0 = shift-sum of three terms, 1 = single half term |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | NRZI-decoded bit, held between strobes |

## Verification
The bound checker watches the output strobe on every cycle. It checks that the strobe never lasts two cycles and that it always follows an accepted sample by exactly three edges. It also checks that the decoded bit holds still between strobes and that reset silences both outputs.

The numeric path cannot be seen from the ports cycle by cycle. This covers the four-sample delay, the arithmetic shifts, the two filter poles, the phase nudging on edges, the majority vote and the NRZI comparison. Only the bench scenarios can show these. The bench feeds synthetic two-tone audio, with and without idle gaps, and compares every decoded bit against an independent model built from the requirements.

// File: rtl/afsk_rx_pkg.sv
package afsk_rx_pkg;

  typedef enum logic {
    LPF_SHIFT3 = 1'b0,
    LPF_HALF   = 1'b1
  } lpf_pole_e;

  function automatic logic vote3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/afsk_delay_mult.sv
module afsk_delay_mult #(
  parameter int SMP_W  = 8,
  parameter int DLY    = 4,
  parameter int X_SHR  = 2,
  localparam int PROD_W = 2 * SMP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_v,
  input  logic [SMP_W-1:0]         in_s,
  output logic                     x_v,
  output logic signed [PROD_W-1:0] x_o
);

  logic signed [SMP_W-1:0] tap_q [DLY];
  logic signed [PROD_W-1:0] cur_ext, old_ext, prod;

  // oldest tap is the sample taken DLY samples ago
  assign cur_ext = PROD_W'($signed(in_s));
  assign old_ext = PROD_W'(tap_q[DLY-1]);
  assign prod    = cur_ext * old_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q[0] <= '0;
    end else if (in_v) begin
      tap_q[0] <= $signed(in_s);
    end
  end

  for (genvar g = 1; g < DLY; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) begin
        tap_q[g] <= '0;
      end else if (in_v) begin
        tap_q[g] <= tap_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_v <= 1'b0;
      x_o <= '0;
    end else begin
      x_v <= in_v;
      if (in_v) begin
        x_o <= prod >>> X_SHR;
      end
    end
  end

endmodule

// File: rtl/afsk_iir.sv
module afsk_iir
  import afsk_rx_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    x_v,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic                    pole,
  output logic                    y_v,
  output logic signed [ACC_W-1:0] y_o
);

  logic signed [ACC_W-1:0] xp_q, y_q, x_ext, base, y_shift3, y_half, y_next;

  assign x_ext    = ACC_W'(x_i);
  assign base     = xp_q + x_ext;
  assign y_half   = base + (y_q >>> 1);
  assign y_shift3 = base + (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);
  assign y_next   = (lpf_pole_e'(pole) == LPF_HALF) ? y_half : y_shift3;

  always_ff @(posedge clk) begin
    if (rst) begin
      xp_q <= '0;
      y_q  <= '0;
      y_v  <= 1'b0;
    end else begin
      y_v <= x_v;
      if (x_v) begin
        xp_q <= x_ext;
        y_q  <= y_next;
      end
    end
  end

  assign y_o = y_q;

endmodule

// File: rtl/afsk_dpll.sv
module afsk_dpll
  import afsk_rx_pkg::*;
#(
  parameter int ACC_W     = 18,
  parameter int SPB       = 8,
  parameter int PHASE_BIT = 8,
  parameter int PHASE_INC = 1,
  localparam int PH_MAX   = SPB * PHASE_BIT,
  localparam int PH_THR   = PH_MAX / 2,
  localparam int PH_W     = $clog2(PH_MAX + PHASE_BIT + PHASE_INC + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    y_v,
  input  logic signed [ACC_W-1:0] y_i,
  output logic                    bit_v,
  output logic                    bit_d
);

  logic [2:0]      hist_q, hist_n;
  logic [PH_W-1:0] ph_q, ph_nudge, ph_adv, ph_n;
  logic            last_q, edge_seen, wrap, raw;

  assign hist_n    = {hist_q[1:0], (y_i > 0)};
  assign edge_seen = hist_n[0] ^ hist_n[1];

  always_comb begin
    ph_nudge = ph_q;
    if (edge_seen) begin
      if (ph_q < PH_W'(PH_THR)) ph_nudge = ph_q + PH_W'(PHASE_INC);
      else                      ph_nudge = ph_q - PH_W'(PHASE_INC);
    end
    ph_adv = ph_nudge + PH_W'(PHASE_BIT);
    wrap   = (ph_adv >= PH_W'(PH_MAX));
    ph_n   = wrap ? ph_adv - PH_W'(PH_MAX) : ph_adv;
  end

  assign raw = vote3(hist_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      ph_q   <= '0;
      last_q <= 1'b0;
      bit_v  <= 1'b0;
      bit_d  <= 1'b0;
    end else begin
      bit_v <= 1'b0;
      if (y_v) begin
        hist_q <= hist_n;
        ph_q   <= ph_n;
        if (wrap) begin
          last_q <= raw;
          bit_v  <= 1'b1;
          bit_d  <= ~(raw ^ last_q);
        end
      end
    end
  end

endmodule

// File: rtl/afsk_bit_recover.sv
module afsk_bit_recover #(
  parameter int SMP_W     = 8,
  parameter int DLY       = 4,
  parameter int X_SHR     = 2,
  parameter int ACC_W     = 18,
  parameter int SPB       = 8,
  parameter int PHASE_BIT = 8,
  parameter int PHASE_INC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             lpf_sel,
  output logic             bit_valid,
  output logic             bit_data
);

  localparam int PROD_W = 2 * SMP_W;

  logic                     x_v, y_v;
  logic signed [PROD_W-1:0] x_w;
  logic signed [ACC_W-1:0]  y_w;

  afsk_delay_mult #(.SMP_W(SMP_W), .DLY(DLY), .X_SHR(X_SHR)) u_disc (
    .clk(clk), .rst(rst), .in_v(smp_valid), .in_s(smp_data),
    .x_v(x_v), .x_o(x_w)
  );

  afsk_iir #(.IN_W(PROD_W), .ACC_W(ACC_W)) u_lpf (
    .clk(clk), .rst(rst), .x_v(x_v), .x_i(x_w), .pole(lpf_sel),
    .y_v(y_v), .y_o(y_w)
  );

  afsk_dpll #(.ACC_W(ACC_W), .SPB(SPB), .PHASE_BIT(PHASE_BIT),
              .PHASE_INC(PHASE_INC)) u_pll (
    .clk(clk), .rst(rst), .y_v(y_v), .y_i(y_w),
    .bit_v(bit_valid), .bit_d(bit_data)
  );

endmodule

// File: rtl/afsk_rx_chk.sv
module afsk_rx_chk (
  input logic clk,
  input logic rst,
  input logic smp_valid,
  input logic bit_valid,
  input logic bit_data
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bit_valid && !bit_data));

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R9
  strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(smp_valid, 3));

  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(bit_data));

endmodule

bind afsk_bit_recover afsk_rx_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid),
  .bit_valid(bit_valid), .bit_data(bit_data)
);

// File: tb/tb_afsk_bit_recover.sv
module tb_afsk_bit_recover;
  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 4;
  // {pole, idle_gaps, amplitude[7:0], bit pattern[15:0]}
  localparam logic [25:0] CASES [NCASE] = '{
    {1'b0, 1'b0, 8'd100, 16'hA5C3},
    {1'b1, 1'b0, 8'd90,  16'h3C96},
    {1'b0, 1'b1, 8'd120, 16'hF00F},
    {1'b1, 1'b1, 8'd60,  16'h5A71}
  };

  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0, lpf_sel = 1'b0;
  logic [7:0] smp_data = '0;
  logic bit_valid, bit_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  afsk_bit_recover dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .lpf_sel(lpf_sel), .bit_valid(bit_valid), .bit_data(bit_data)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int n_got = 0;
  bit got_bits [1024];
  int n_exp;
  bit exp_bits [256];

  // decoded-bit monitor
  always @(negedge clk) begin
    if (!rst && bit_valid) begin
      if (n_got < 1024) got_bits[n_got] = bit_data;
      n_got++;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state, built from the requirements
  int md [4];
  int mxp, my, mph;
  bit [2:0] mh;
  bit mlast;

  task automatic model_clear();
    for (int i = 0; i < 4; i++) md[i] = 0;
    mxp = 0; my = 0; mph = 0; mh = '0; mlast = 1'b0; n_exp = 0;
  endtask

  task automatic model_step(input int s, input bit pole);
    int old, x, yn;
    bit b;
    old = md[3];
    md[3] = md[2]; md[2] = md[1]; md[1] = md[0]; md[0] = s;
    x = (old * s) >>> 2;
    if (pole) yn = mxp + x + (my >>> 1);
    else      yn = mxp + x + (my >>> 1) + (my >>> 3) + (my >>> 5);
    mxp = x; my = yn;
    mh = {mh[1:0], (yn > 0)};
    if (mh[0] != mh[1]) mph = (mph < 32) ? mph + 1 : mph - 1;
    mph += 8;
    if (mph >= 64) begin
      mph -= 64;
      b = (int'(mh[0]) + int'(mh[1]) + int'(mh[2])) >= 2;
      if (n_exp < 256) exp_bits[n_exp] = (b == mlast);
      n_exp++;
      mlast = b;
    end
  endtask

  task automatic push(input int s);
    smp_valid = 1'b1;
    smp_data  = s[7:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // silence after reset: first strobe on the 8th sample, then every 8
  task automatic silence_run(input string tag);
    int base;
    base = n_got;
    for (int i = 0; i < 7; i++) push(0);
    check_eq({tag, " R6 no bit before 8th sample"}, n_got - base, 0);
    push(0);
    check_eq({tag, " R9 strobe low after edge 1"}, int'(bit_valid), 0);
    @(negedge clk);
    check_eq({tag, " R9 strobe low after edge 2"}, int'(bit_valid), 0);
    @(negedge clk);
    check_eq({tag, " R9 strobe high after edge 3"}, int'(bit_valid), 1);
    check_eq({tag, " R8 silence decodes to 1"}, int'(bit_data), 1);
    @(negedge clk);
    check_eq({tag, " R9 strobe one cycle"}, int'(bit_valid), 0);
    for (int i = 0; i < 56; i++) push(0);
    repeat (4) @(negedge clk);
    check_eq({tag, " R6 eight bits per 64 samples"}, n_got - base, 8);
    for (int j = 0; j < 8; j++)
      check_eq({tag, " R5/R7/R8 silent bit value"}, int'(got_bits[base + j]), 1);
  endtask

  task automatic run_case(input logic [25:0] c);
    bit pole, gaps;
    int amp, acc, s, base;
    logic [15:0] pat;
    pole = c[25]; gaps = c[24]; amp = int'(c[23:16]); pat = c[15:0];
    do_reset();
    model_clear();
    lpf_sel = pole;
    base = n_got;
    for (int i = 0; i < 3; i++) begin
      model_step(0, pole);
      push(0);
    end
    acc = 0;
    for (int b = 0; b < 32; b++) begin
      for (int k = 0; k < 8; k++) begin
        acc = (acc + (pat[b % 16] ? 64 : 117)) % 512;
        s = $rtoi($floor(amp * $sin(2.0 * 3.14159265358979 * acc / 512.0) + 0.5));
        model_step(s, pole);
        push(s);
        if (gaps && k == 3) begin
          // R10: idle cycles with junk on the data bus
          for (int g = 0; g < 2; g++) begin
            smp_data = 8'($urandom);
            @(negedge clk);
          end
        end
      end
    end
    repeat (5) @(negedge clk);
    check_eq($sformatf("case pole=%0d gaps=%0d R6 bit count", pole, gaps),
             n_got - base, n_exp);
    for (int j = 0; j < n_exp && j < 256; j++)
      check_eq($sformatf("case pole=%0d gaps=%0d bit %0d R2/R3/R4/R5/R7/R8/R10",
               pole, gaps, j), int'(got_bits[base + j]), int'(exp_bits[j]));
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check_eq("R1 bit_valid in reset", int'(bit_valid), 0);
    check_eq("R1 bit_data in reset", int'(bit_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 bit_valid after reset", int'(bit_valid), 0);

    // R10: idle cycles with junk produce nothing and move no phase
    begin
      int base;
      base = n_got;
      for (int i = 0; i < 40; i++) begin
        smp_data = 8'($urandom);
        @(negedge clk);
      end
      check_eq("R10 no bits while idle", n_got - base, 0);
    end
    silence_run("post-reset");

    // table of tone stimulus, each compared against the model
    for (int ci = 0; ci < NCASE; ci++) run_case(CASES[ci]);

    // reset in the middle of activity clears phase and previous bit
    lpf_sel = 1'b0;
    for (int i = 0; i < 21; i++) push((i % 2 == 0) ? 90 : -70);
    do_reset();
    check_eq("R1 bit_data cleared by reset", int'(bit_data), 0);
    silence_run("mid-run reset R1");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule